// File: doc/BRIEF.md
# SPI Burst Sample Reader

This block is an SPI master that collects a burst of 32-bit samples from a single data-producing slave and stores them in a local buffer. Ownership of that buffer moves between the host and the master through a one-bit semaphore. While the host owns the buffer, the master stays idle. The host hands the buffer over with a single-cycle `grant` pulse. The master then raises `busy` and runs a fixed number of transactions. After the last sample is stored, it drops `busy`, pulses `done`, and ownership returns to the host.

Each transaction uses clock polarity 0 and samples on the rising edge. Chip select is lowered, 32 SCLK periods are generated, and MISO is shifted in most significant bit first on every rising SCLK edge. The completed word is written to the next buffer location, counting up from index 0. Chip select then stays high for three half-periods before the next transaction starts. The duration of a half-period is a parameter, given in system clocks. MOSI carries no payload and stays low.

The host reads the buffer through an asynchronous read port. The port shows stored words only while the host owns the semaphore. While the master owns it, the port reads zero.

Top module: `spi_burst_reader`

## Requirements
- R1: While reset is asserted, and after it is released with no grant, `cs_n` is 1, `sclk` is 0, `mosi` is 0, `busy` is 0 and `done` is 0.
- R2: A `grant` pulse seen while `busy` is 0 makes `busy` 1 and `cs_n` 0 on the next clock edge. A `grant` seen while `busy` is 1 is ignored: the burst keeps its transaction count and `done` still pulses exactly once.
- R3: SCLK is 0 whenever `cs_n` is 1. Every low period of `cs_n` contains exactly WORD_W (32) rising SCLK edges.
- R4: Each SCLK high phase lasts HALF_CYCLES clocks. Each SCLK low phase inside a transaction also lasts HALF_CYCLES clocks, and that includes the first low phase, which is counted from the falling edge of `cs_n`.
- R5: MISO is sampled on each rising SCLK edge. The first bit sampled becomes bit 31 of the stored word, and the last bit sampled becomes bit 0.
- R6: Transaction k of a burst (k starts at 0) is stored at buffer index k.
- R7: Between two transactions of one burst, `cs_n` stays high for exactly 3*HALF_CYCLES clocks.
- R8: A burst contains exactly NUM_WORDS transactions. After the last inter-word gap, `busy` falls and `done` is 1 for exactly one clock, in the same cycle in which `busy` is first 0.
- R9: `rd_data` is 0 while `busy` is 1. While `busy` is 0, `rd_data` is the word stored at `rd_addr`, with no clock of delay.
- R10: `mosi` is 0 at all times.
- R11: Asserting reset in the middle of a burst immediately returns `cs_n` to 1, `sclk` to 0 and `busy` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| grant | input | 1 | Host releases the semaphore, which starts a burst when the master is idle |
| busy | output | 1 | Master owns the semaphore and the buffer |
| done | output | 1 | One-cycle pulse when the master returns ownership to the host |
| rd_addr | input | $clog2(NUM_WORDS) | Host read index |
| rd_data | output | WORD_W | Stored word at `rd_addr`; zero while busy |
| cs_n | output | 1 | SPI chip select, active low |
| sclk | output | 1 | SPI clock, idles low |
| mosi | output | 1 | SPI master data out, held low |
| miso | input | 1 | SPI slave data in |

## Verification
A wrong bit counter shows up at the first rise of `cs_n`, because the number of SCLK rises in that low period is not 32. A half-period timer that loads the wrong value changes the length of the first SCLK phase, which falls within HALF_CYCLES clocks of the grant. A broken word index or shift direction does not show on the SPI pins. It becomes visible only when the host reads the buffer after `done`, where words show up bit-reversed, shifted or in the wrong slot. A stuck ownership bit shows either as `done` never arriving, or as nonzero read data while `busy` is high.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_HIGH = 2'd2,
    ST_GAP  = 2'd3
  } burst_state_e;
endpackage

// File: rtl/spi_phase_timer.sv
module spi_phase_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (load) begin
      cnt_en = 1'b1;
      cnt_d  = load_val;
    end else if (cnt_q != '0) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/spi_shift_in.sv
module spi_shift_in #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              bit_in,
  output logic [WORD_W-1:0] word
);
  logic [WORD_W-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sh_q <= '0;
    else if (shift_en) sh_q <= {sh_q[WORD_W-2:0], bit_in};
  end

  assign word = sh_q;
endmodule

// File: rtl/sample_buffer.sv
module sample_buffer #(
  parameter int WORD_W = 32,
  parameter int DEPTH  = 128,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [WORD_W-1:0] rd_data
);
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/spi_burst_reader.sv
module spi_burst_reader #(
  parameter int WORD_W      = 32,
  parameter int NUM_WORDS   = 128,
  parameter int HALF_CYCLES = 50,
  parameter int GAP_HALVES  = 3,
  localparam int AW         = $clog2(NUM_WORDS),
  localparam int BIT_W      = $clog2(WORD_W),
  localparam int GAP_CYCLES = GAP_HALVES * HALF_CYCLES,
  localparam int TMR_W      = $clog2(GAP_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              grant,
  output logic              busy,
  output logic              done,
  input  logic [AW-1:0]     rd_addr,
  output logic [WORD_W-1:0] rd_data,
  output logic              cs_n,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso
);
  import spi_burst_pkg::*;

  localparam logic [TMR_W-1:0] HALF_LOAD = TMR_W'(HALF_CYCLES - 1);
  localparam logic [TMR_W-1:0] GAP_LOAD  = TMR_W'(GAP_CYCLES - 1);
  localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(WORD_W - 1);
  localparam logic [AW-1:0]    LAST_IDX  = AW'(NUM_WORDS - 1);

  burst_state_e     state_q, state_d;
  logic             cs_n_q, cs_n_d;
  logic             sclk_q, sclk_d;
  logic             busy_q, busy_d;
  logic             done_q, done_d;
  logic [BIT_W-1:0] bit_q, bit_d;
  logic [AW-1:0]    idx_q, idx_d;

  logic             tmr_load;
  logic [TMR_W-1:0] tmr_val;
  logic             tmr_zero;
  logic             shift_en;
  logic             wr_en;
  logic [WORD_W-1:0] rx_word;
  logic [WORD_W-1:0] buf_rd;

  spi_phase_timer #(.CNT_W(TMR_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_zero)
  );

  spi_shift_in #(.WORD_W(WORD_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (shift_en),
    .bit_in   (miso),
    .word     (rx_word)
  );

  sample_buffer #(.WORD_W(WORD_W), .DEPTH(NUM_WORDS)) u_buf (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (idx_q),
    .wr_data (rx_word),
    .rd_addr (rd_addr),
    .rd_data (buf_rd)
  );

  // Next-state logic
  always_comb begin
    state_d  = state_q;
    cs_n_d   = cs_n_q;
    sclk_d   = sclk_q;
    busy_d   = busy_q;
    done_d   = 1'b0;
    bit_d    = bit_q;
    idx_d    = idx_q;
    tmr_load = 1'b0;
    tmr_val  = HALF_LOAD;
    shift_en = 1'b0;
    wr_en    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (grant) begin
          state_d  = ST_LOW;
          cs_n_d   = 1'b0;
          busy_d   = 1'b1;
          bit_d    = '0;
          idx_d    = '0;
          tmr_load = 1'b1;
        end
      end
      ST_LOW: begin
        if (tmr_zero) begin
          state_d  = ST_HIGH;
          sclk_d   = 1'b1;
          shift_en = 1'b1;
          tmr_load = 1'b1;
        end
      end
      ST_HIGH: begin
        if (tmr_zero) begin
          sclk_d   = 1'b0;
          tmr_load = 1'b1;
          if (bit_q == LAST_BIT) begin
            state_d = ST_GAP;
            cs_n_d  = 1'b1;
            wr_en   = 1'b1;
            tmr_val = GAP_LOAD;
          end else begin
            state_d = ST_LOW;
            bit_d   = bit_q + 1'b1;
          end
        end
      end
      ST_GAP: begin
        if (tmr_zero) begin
          if (idx_q == LAST_IDX) begin
            state_d = ST_IDLE;
            busy_d  = 1'b0;
            done_d  = 1'b1;
          end else begin
            state_d  = ST_LOW;
            cs_n_d   = 1'b0;
            bit_d    = '0;
            idx_d    = idx_q + 1'b1;
            tmr_load = 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cs_n_q  <= 1'b1;
      sclk_q  <= 1'b0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      bit_q   <= '0;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      cs_n_q  <= cs_n_d;
      sclk_q  <= sclk_d;
      busy_q  <= busy_d;
      done_q  <= done_d;
      bit_q   <= bit_d;
      idx_q   <= idx_d;
    end
  end

  assign cs_n    = cs_n_q;
  assign sclk    = sclk_q;
  assign busy    = busy_q;
  assign done    = done_q;
  assign mosi    = 1'b0;
  assign rd_data = busy_q ? '0 : buf_rd;
endmodule

// File: rtl/spi_burst_reader_chk.sv
module spi_burst_reader_chk #(
  parameter int WORD_W      = 32,
  parameter int HALF_CYCLES = 50
) (
  input logic              clk,
  input logic              rst_n,
  input logic              grant,
  input logic              busy,
  input logic              done,
  input logic [WORD_W-1:0] rd_data,
  input logic              cs_n,
  input logic              sclk,
  input logic              mosi
);
  logic [15:0] hi_len;
  logic [15:0] rise_cnt;
  logic        sclk_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_len    <= '0;
      rise_cnt  <= '0;
      sclk_prev <= 1'b0;
    end else begin
      sclk_prev <= sclk;
      hi_len    <= sclk ? hi_len + 1'b1 : '0;
      if (cs_n)                rise_cnt <= '0;
      else if (sclk && !sclk_prev) rise_cnt <= rise_cnt + 1'b1;
    end
  end

  p_mosi_low_r10: assert property (@(posedge clk) disable iff (!rst_n) !mosi);
  p_sclk_idle_r3: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> !sclk);
  p_rise_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> rise_cnt == 16'(WORD_W));
  p_high_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk) |-> hi_len == 16'(HALF_CYCLES));
  p_grant_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && !busy) |=> (busy && !cs_n));
  p_cs_owned_r2: assert property (@(posedge clk) disable iff (!rst_n) !cs_n |-> busy);
  p_done_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  p_read_blank_r9: assert property (@(posedge clk) disable iff (!rst_n) busy |-> rd_data == '0);
endmodule

bind spi_burst_reader spi_burst_reader_chk #(
  .WORD_W(WORD_W), .HALF_CYCLES(HALF_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .grant(grant), .busy(busy), .done(done),
  .rd_data(rd_data), .cs_n(cs_n), .sclk(sclk), .mosi(mosi)
);

// File: tb/spi_burst_reader_test.sv
module spi_burst_reader_test;
  localparam int W    = 32;
  localparam int NW   = 16;
  localparam int HALF = 2;
  localparam int AW   = $clog2(NW);
  localparam int NV   = 4;
  localparam logic [31:0] SEED [NV] = '{32'h0000_0000, 32'hFFFF_FFFF, 32'h8000_0001, 32'hA5A5_A5A5};
  localparam logic [31:0] MUL  [NV] = '{32'h0000_0000, 32'h0000_0000, 32'h0001_0001, 32'h9E37_79B9};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic grant = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic miso = 1'b0;
  logic busy, done, cs_n, sclk, mosi;
  logic [W-1:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  spi_burst_reader #(.WORD_W(W), .NUM_WORDS(NW), .HALF_CYCLES(HALF)) uut (
    .clk(clk), .rst_n(rst_n), .grant(grant), .busy(busy), .done(done),
    .rd_addr(rd_addr), .rd_data(rd_data), .cs_n(cs_n), .sclk(sclk),
    .mosi(mosi), .miso(miso)
  );

  function automatic logic [31:0] pat(int v, int n);
    return SEED[v] ^ (MUL[v] * 32'(n));
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Slave model: MSB on CS fall, next bit after each SCLK fall
  int cur_v = 0;
  int tx_idx = 0;
  int bitpos = 0;
  always @(negedge cs_n) begin
    bitpos = 31;
    miso = pat(cur_v, tx_idx)[31];
  end
  always @(negedge sclk) begin
    if (bitpos > 0) begin
      bitpos = bitpos - 1;
      miso = pat(cur_v, tx_idx)[bitpos];
    end
  end
  always @(posedge cs_n) tx_idx = tx_idx + 1;

  // Pin monitor, sampled on the falling clock edge
  logic prev_sclk = 1'b0, prev_cs = 1'b1;
  int run = 0, rises = 0, cs_falls = 0, done_pulses = 0;
  int bad_hi = 0, bad_lo = 0, bad_gap = 0, bad_rises = 0, mosi_hi = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (mosi) mosi_hi++;
      if (done) done_pulses++;
      if (sclk !== prev_sclk || cs_n !== prev_cs) begin
        if (!prev_cs && prev_sclk && run != HALF) bad_hi++;
        if (!prev_cs && !prev_sclk && sclk && run != HALF) bad_lo++;
        if (prev_cs && !cs_n && cs_falls > 0 && run != 3*HALF) bad_gap++;
        if (!prev_sclk && sclk) rises++;
        if (!prev_cs && cs_n) begin
          if (rises != W) bad_rises++;
          rises = 0;
        end
        if (prev_cs && !cs_n) cs_falls++;
        run = 1;
      end else begin
        run++;
      end
    end
    prev_sclk = sclk;
    prev_cs   = cs_n;
  end

  task automatic clear_mon();
    rises = 0; cs_falls = 0; done_pulses = 0;
    bad_hi = 0; bad_lo = 0; bad_gap = 0; bad_rises = 0;
    tx_idx = 0;
  endtask

  task automatic pulse_grant();
    @(posedge clk); #1 grant = 1'b1;
    @(posedge clk); #1 grant = 1'b0;
  endtask

  task automatic wait_idle();
    int guard = 0;
    while (busy && guard < 50000) begin
      @(posedge clk); #1;
      guard++;
    end
  endtask

  task automatic check_burst(input int v, input bit extra_grant);
    clear_mon();
    cur_v = v;
    pulse_grant();
    check(busy === 1'b1 && cs_n === 1'b0, "R2 start", {30'd0, busy, cs_n}, 32'h2);
    if (extra_grant) begin
      repeat (200) @(posedge clk);
      #1 rd_addr = '0;
      #1 check(rd_data === '0, "R9 blank while busy", rd_data, 32'h0);
      pulse_grant();
    end
    wait_idle();
    check(done === 1'b1, "R8 done with release", {31'd0, done}, 32'h1);
    @(posedge clk); #1;
    check(done === 1'b0, "R8 done single", {31'd0, done}, 32'h0);
    check(cs_falls == NW, "R8 transaction count", cs_falls, NW);
    check(done_pulses == 1, "R2 R8 one done", done_pulses, 1);
    check(bad_rises == 0, "R3 rises per word", bad_rises, 0);
    check(bad_hi == 0 && bad_lo == 0, "R4 phase length", bad_hi + bad_lo, 0);
    check(bad_gap == 0, "R7 cs gap", bad_gap, 0);
    for (int i = 0; i < NW; i++) begin
      rd_addr = AW'(i);
      #1 check(rd_data === pat(v, i), "R5 R6 stored word", rd_data, pat(v, i));
    end
  endtask

  initial begin
    #1600000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    #1 check(cs_n === 1'b1 && sclk === 1'b0 && busy === 1'b0 && done === 1'b0,
             "R1 in reset", {28'd0, cs_n, sclk, busy, done}, 32'h8);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (5) @(posedge clk);
    #1 check(cs_n === 1'b1 && sclk === 1'b0 && busy === 1'b0,
             "R1 idle after reset", {29'd0, cs_n, sclk, busy}, 32'h4);

    // Vector table walk
    for (int v = 0; v < NV; v++) check_burst(v, 1'b0);

    // R2, R9: grant while busy is ignored; read port blank while busy
    check_burst(1, 1'b1);

    // R11: reset mid-burst
    clear_mon();
    cur_v = 2;
    pulse_grant();
    repeat (150) @(posedge clk);
    #1 rst_n = 1'b0;
    #1 check(cs_n === 1'b1 && sclk === 1'b0 && busy === 1'b0,
             "R11 abort", {29'd0, cs_n, sclk, busy}, 32'h4);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (20) @(posedge clk);
    #1 check(busy === 1'b0 && cs_n === 1'b1, "R11 stays idle", {30'd0, busy, cs_n}, 32'h1);

    // Full burst after the abort
    check_burst(3, 1'b0);

    // R10: MOSI never high
    check(mosi_hi == 0, "R10 mosi low", mosi_hi, 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule